// File: doc/BRIEF.md
# CPU Register and Pointer Unit

This unit holds the registers a program can see in a small 8-bit microcontroller core whose program memory and data RAM are separate. It keeps an accumulator, a 15-bit program counter, two 8-bit data-RAM pointers and an 8-bit stack pointer. Decode logic outside the unit reaches every register through one write port and one read port, both addressed by a 3-bit select code. The program counter appears there as two bytes: a low byte of 8 bits and a high byte of 7 bits.

The same decode logic drives three more kinds of request. A pointer-use strobe picks one of the two pointers to address data RAM and modifies that pointer after the access as a 2-bit mode code asks. Push and pop strobes run the stack that subroutine calls and interrupts share. Load and increment controls step the program counter. The unit drives the data-RAM address and the program counter on two separate buses, because the two memories have separate address spaces.

Top module: `cpu_reg_unit`

## Requirements
- R1: While reset is held low at a clock edge, the accumulator, both pointers and the program counter clear to zero. The stack pointer loads 0x2F when RAM_BYTES is 64 and 0x6F when RAM_BYTES is 128.
- R2: The select codes are 0 accumulator, 1 pointer P0, 2 pointer P1, 3 stack pointer, 4 PC low byte and 5 PC high byte. A write with wr_en_i high updates the chosen register at the next edge. rd_data_o shows the chosen register in the same cycle. Codes 6 and 7 read as zero, and a write with those codes changes no register.
- R3: A write to the PC high byte stores data bits 6:0 into PC bits 14:8 and ignores data bit 7. A read of the PC high byte returns zero in bit 7.
- R4: When pc_inc_i is high and no load or PC byte write happens in the same cycle, the PC adds one. The carry passes from the low byte into the high byte, and 0x7FFF wraps to 0x0000.
- R5: pc_load_i loads all 15 bits from pc_load_val_i. A load overrides a PC byte write, and a PC byte write overrides an increment.
- R6: With use_en_i high, use_ptr_i picks P0 (0) or P1 (1). ram_addr_o shows that pointer's value before any change. At the next edge the pointer changes by mode code: 00 leaves it unchanged, 01 adds one, 10 subtracts one, and 11 leaves it unchanged. Changes wrap modulo 256.
- R7: If a pointer is written through the write port in the same cycle it is used, the written value wins over the post-modify.
- R8: On a push, ram_addr_o equals the stack pointer and the stack pointer then drops by one. On a pop, ram_addr_o equals the stack pointer plus one and the stack pointer then rises by one. A push wins over a pop, and either one wins the address over a pointer use. A stack-pointer write wins over both.
- R9: Stack-pointer changes wrap modulo 256.
- R10: pc_o always shows the current program counter. When no stack access is made, ram_addr_o shows the pointer that use_ptr_i picks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register write port |
| wr_sel_i | input | 3 | Select code of the register to write |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 3 | Select code of the register to read |
| rd_data_o | output | 8 | Read data, combinational |
| use_en_i | input | 1 | Pointer-use strobe |
| use_ptr_i | input | 1 | Pointer choice: 0 P0, 1 P1 |
| use_mode_i | input | 2 | Post-modify code |
| pc_load_i | input | 1 | Full PC load strobe |
| pc_load_val_i | input | 15 | Value for a full PC load |
| pc_inc_i | input | 1 | PC increment strobe |
| push_i | input | 1 | Stack push strobe |
| pop_i | input | 1 | Stack pop strobe |
| ram_addr_o | output | 8 | Data RAM address |
| pc_o | output | 15 | Program counter |

## Verification
The assertions assume every control input carries a known value once reset is released. They also assume that strobes which collide are resolved by the priorities R5, R7 and R8 define, so each step property is guarded by the absence of the strobes that outrank it. The stimulus draws every control and data input from $urandom with a fixed seed and sets each strobe's probability to match how often it is used, so collisions such as push with pop, load with increment, and a write to a pointer in its own use cycle occur many times. Directed runs then force the wrap points at 0xFF, 0x00 and 0x7FFF, write bit 7 of the PC high byte, and try the unused select codes.

// File: rtl/cru_pkg.sv
// Package: select codes and pointer modes shared by the register unit.
// Assumes the 3-bit select field and the 2-bit mode field are fixed by decode.
package cru_pkg;

    typedef enum logic [2:0] {
        SEL_ACC  = 3'd0,
        SEL_PTR0 = 3'd1,
        SEL_PTR1 = 3'd2,
        SEL_STK  = 3'd3,
        SEL_PCLO = 3'd4,
        SEL_PCHI = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_INC  = 2'b01,
        MODE_DEC  = 2'b10,
        MODE_RSVD = 2'b11
    } ptr_mode_e;

    localparam int NUM_PTR = 2;

endpackage

// File: rtl/cru_ptr_reg.sv
// Module: one data-RAM pointer with optional post-modify on use.
// Assumes: a write through the register port outranks the post-modify, and
// the arithmetic wraps at the register width.
module cru_ptr_reg
    import cru_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          use_en,
    input  logic [1:0]    use_mode,
    output logic [DW-1:0] val
);

    logic [DW-1:0] val_d;

    // Next value: post-modify first, then let a port write override it.
    always_comb begin
        val_d = val;
        if (use_en) begin
            case (ptr_mode_e'(use_mode))
                MODE_INC: val_d = val + DW'(1);
                MODE_DEC: val_d = val - DW'(1);
                default:  val_d = val;
            endcase
        end
        if (wr_en) begin
            val_d = wr_data;
        end
    end

    // Pointer storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '0;
        end else begin
            val <= val_d;
        end
    end

endmodule

// File: rtl/cru_pc_reg.sv
// Module: program counter split into a full-width low byte and a short high part.
// Assumes: PC_W > DW and PC_W <= 2*DW; priority is load, then byte write, then step.
module cru_pc_reg #(
    parameter int DW   = 8,
    parameter int PC_W = 15,
    localparam int HI_W = PC_W - DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PC_W-1:0] load_val,
    input  logic            wr_lo,
    input  logic [DW-1:0]   lo_data,
    input  logic            wr_hi,
    input  logic [HI_W-1:0] hi_data,
    input  logic            inc,
    output logic [PC_W-1:0] pc
);

    logic [PC_W-1:0] pc_d;

    // Next PC from the strongest active request.
    always_comb begin
        if (load) begin
            pc_d = load_val;
        end else if (wr_lo) begin
            pc_d = {pc[PC_W-1:DW], lo_data};
        end else if (wr_hi) begin
            pc_d = {hi_data, pc[DW-1:0]};
        end else if (inc) begin
            pc_d = pc + PC_W'(1);
        end else begin
            pc_d = pc;
        end
    end

    // PC storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else begin
            pc <= pc_d;
        end
    end

endmodule

// File: rtl/cru_stack_ptr.sv
// Module: stack pointer; push uses then decrements, pop increments then uses.
// Assumes: push outranks pop and a port write outranks both.
module cru_stack_ptr #(
    parameter int          DW   = 8,
    parameter logic [DW-1:0] INIT = 8'h2F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          push,
    input  logic          pop,
    output logic [DW-1:0] sp,
    output logic [DW-1:0] sp_up
);

    logic [DW-1:0] sp_down;
    logic [DW-1:0] sp_d;

    // Neighbour addresses, shared by the pop address path and the update.
    always_comb begin
        sp_up   = sp + DW'(1);
        sp_down = sp - DW'(1);
    end

    // Next stack pointer by priority.
    always_comb begin
        if (wr_en) begin
            sp_d = wr_data;
        end else if (push) begin
            sp_d = sp_down;
        end else if (pop) begin
            sp_d = sp_up;
        end else begin
            sp_d = sp;
        end
    end

    // Stack pointer storage; reset value set by RAM size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= INIT;
        end else begin
            sp <= sp_d;
        end
    end

endmodule

// File: rtl/cpu_reg_unit.sv
// Module: top of the register unit. Holds the accumulator, two post-modify
// pointers, the stack pointer and the program counter, and drives the
// data-RAM address and PC buses.
// Assumes: RAM_BYTES is 64 or 128; control strobes are known after reset.
module cpu_reg_unit
    import cru_pkg::*;
#(
    parameter int DW        = 8,
    parameter int PC_W      = 15,
    parameter int RAM_BYTES = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [2:0]      wr_sel_i,
    input  logic [DW-1:0]   wr_data_i,
    input  logic [2:0]      rd_sel_i,
    output logic [DW-1:0]   rd_data_o,
    input  logic            use_en_i,
    input  logic            use_ptr_i,
    input  logic [1:0]      use_mode_i,
    input  logic            pc_load_i,
    input  logic [PC_W-1:0] pc_load_val_i,
    input  logic            pc_inc_i,
    input  logic            push_i,
    input  logic            pop_i,
    output logic [DW-1:0]   ram_addr_o,
    output logic [PC_W-1:0] pc_o
);

    localparam int            HI_W    = PC_W - DW;
    localparam logic [DW-1:0] SP_INIT = DW'(RAM_BYTES - 17);

    logic [DW-1:0]   acc_q;
    logic [DW-1:0]   ptr_q [NUM_PTR];
    logic [DW-1:0]   sp_q;
    logic [DW-1:0]   sp_up;
    logic [PC_W-1:0] pc_q;
    reg_sel_e        wsel;
    reg_sel_e        rsel;

    // Decode the select fields once.
    always_comb begin
        wsel = reg_sel_e'(wr_sel_i);
        rsel = reg_sel_e'(rd_sel_i);
    end

    // Accumulator storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (wr_en_i && wsel == SEL_ACC) begin
            acc_q <= wr_data_i;
        end
    end

    // One pointer instance per data-RAM pointer.
    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        localparam reg_sel_e MY_SEL = (g == 0) ? SEL_PTR0 : SEL_PTR1;
        cru_ptr_reg #(.DW(DW)) ptr_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en_i && wsel == MY_SEL),
            .wr_data  (wr_data_i),
            .use_en   (use_en_i && use_ptr_i == 1'(g)),
            .use_mode (use_mode_i),
            .val      (ptr_q[g])
        );
    end

    cru_stack_ptr #(.DW(DW), .INIT(SP_INIT)) stk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i && wsel == SEL_STK),
        .wr_data (wr_data_i),
        .push    (push_i),
        .pop     (pop_i),
        .sp      (sp_q),
        .sp_up   (sp_up)
    );

    cru_pc_reg #(.DW(DW), .PC_W(PC_W)) pc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pc_load_i),
        .load_val (pc_load_val_i),
        .wr_lo    (wr_en_i && wsel == SEL_PCLO),
        .lo_data  (wr_data_i),
        .wr_hi    (wr_en_i && wsel == SEL_PCHI),
        .hi_data  (wr_data_i[HI_W-1:0]),
        .inc      (pc_inc_i),
        .pc       (pc_q)
    );

    // Read port multiplexer; unused codes read as zero.
    always_comb begin
        case (rsel)
            SEL_ACC:  rd_data_o = acc_q;
            SEL_PTR0: rd_data_o = ptr_q[0];
            SEL_PTR1: rd_data_o = ptr_q[1];
            SEL_STK:  rd_data_o = sp_q;
            SEL_PCLO: rd_data_o = pc_q[DW-1:0];
            SEL_PCHI: rd_data_o = DW'(pc_q[PC_W-1:DW]);
            default:  rd_data_o = '0;
        endcase
    end

    // Data-RAM address: stack access first, then the chosen pointer.
    always_comb begin
        if (push_i) begin
            ram_addr_o = sp_q;
        end else if (pop_i) begin
            ram_addr_o = sp_up;
        end else begin
            ram_addr_o = ptr_q[use_ptr_i];
        end
    end

    // Program counter bus.
    always_comb begin
        pc_o = pc_q;
    end

endmodule

// File: rtl/cpu_reg_unit_chk.sv
// Module: property checker for the register unit, bound to every instance.
// Assumes: it sees the unit's internal registers through the bind connections.
module cpu_reg_unit_chk
    import cru_pkg::*;
#(
    parameter int            DW      = 8,
    parameter int            PC_W    = 15,
    parameter logic [DW-1:0] SP_INIT = 8'h2F
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [2:0]      wr_sel,
    input logic [DW-1:0]   wr_data,
    input logic            use_en,
    input logic            use_ptr,
    input logic [1:0]      use_mode,
    input logic            pc_load,
    input logic [PC_W-1:0] pc_load_val,
    input logic            pc_inc,
    input logic            push,
    input logic            pop,
    input logic [DW-1:0]   ram_addr,
    input logic [PC_W-1:0] pc,
    input logic [DW-1:0]   ptr0_val,
    input logic [DW-1:0]   ptr1_val,
    input logic [DW-1:0]   sp_val
);

    localparam int HI_W = PC_W - DW;

    AST_SP_INIT: assert property (@(posedge clk)
        !rst_n |=> sp_val == SP_INIT); // R1

    AST_PTR0_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (use_en && !use_ptr && use_mode == 2'b01 && !(wr_en && wr_sel == 3'd1))
        |=> ptr0_val == DW'($past(ptr0_val) + DW'(1))); // R6

    AST_PTR1_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd2) |=> ptr1_val == $past(wr_data)); // R7

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && !pc_load && !(wr_en && (wr_sel == 3'd4 || wr_sel == 3'd5)))
        |=> pc == PC_W'($past(pc) + PC_W'(1))); // R4

    AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> pc == $past(pc_load_val)); // R5

    AST_PC_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd5 && !pc_load)
        |=> pc[PC_W-1:DW] == $past(wr_data[HI_W-1:0])); // R3

    AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ram_addr == sp_val); // R8

    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !(wr_en && wr_sel == 3'd3))
        |=> sp_val == DW'($past(sp_val) - DW'(1))); // R8

    AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !(wr_en && wr_sel == 3'd3))
        |=> sp_val == DW'($past(sp_val) + DW'(1))); // R9

endmodule

bind cpu_reg_unit cpu_reg_unit_chk #(
    .DW      (DW),
    .PC_W    (PC_W),
    .SP_INIT (SP_INIT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en_i),
    .wr_sel      (wr_sel_i),
    .wr_data     (wr_data_i),
    .use_en      (use_en_i),
    .use_ptr     (use_ptr_i),
    .use_mode    (use_mode_i),
    .pc_load     (pc_load_i),
    .pc_load_val (pc_load_val_i),
    .pc_inc      (pc_inc_i),
    .push        (push_i),
    .pop         (pop_i),
    .ram_addr    (ram_addr_o),
    .pc          (pc_o),
    .ptr0_val    (ptr_q[0]),
    .ptr1_val    (ptr_q[1]),
    .sp_val      (sp_q)
);

// File: tb/cpu_reg_unit_tb_top.sv
// Bench: seeded random stimulus plus directed corners, checked against a
// reference model built from the requirements.
module cpu_reg_unit_tb_top;

    localparam int RAM_BYTES = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_sel_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic [2:0]  rd_sel_i = '0;
    logic [7:0]  rd_data_o;
    logic        use_en_i = 1'b0;
    logic        use_ptr_i = 1'b0;
    logic [1:0]  use_mode_i = '0;
    logic        pc_load_i = 1'b0;
    logic [14:0] pc_load_val_i = '0;
    logic        pc_inc_i = 1'b0;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic [7:0]  ram_addr_o;
    logic [14:0] pc_o;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    logic [7:0]  m_a, m_b, m_x, m_sp;
    logic [14:0] m_pc;

    always #10 clk = ~clk;

    cpu_reg_unit #(.RAM_BYTES(RAM_BYTES)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
        .use_en_i(use_en_i), .use_ptr_i(use_ptr_i), .use_mode_i(use_mode_i),
        .pc_load_i(pc_load_i), .pc_load_val_i(pc_load_val_i), .pc_inc_i(pc_inc_i),
        .push_i(push_i), .pop_i(pop_i), .ram_addr_o(ram_addr_o), .pc_o(pc_o)
    );

    task automatic chk(string what, logic [14:0] act, logic [14:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(logic [2:0] s);
        case (s)
            3'd0: return m_a;
            3'd1: return m_b;
            3'd2: return m_x;
            3'd3: return m_sp;
            3'd4: return m_pc[7:0];
            3'd5: return {1'b0, m_pc[14:8]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_addr();
        if (push_i) return m_sp;
        if (pop_i) return m_sp + 8'd1;
        return use_ptr_i ? m_x : m_b;
    endfunction

    function automatic logic [7:0] post_mod(logic [7:0] p, logic [1:0] mode);
        case (mode)
            2'b01: return p + 8'd1;
            2'b10: return p - 8'd1;
            default: return p;
        endcase
    endfunction

    // One clock: check outputs mid-cycle, predict, advance.
    task automatic cycle();
        logic [7:0]  na, nb, nx, nsp;
        logic [14:0] npc;
        #1;
        chk("R2 read port", 15'(rd_data_o), 15'(exp_rd(rd_sel_i)));
        chk("R6 or R8 ram address", 15'(ram_addr_o), 15'(exp_addr()));
        chk("R10 pc bus", pc_o, m_pc);
        na = m_a; nb = m_b; nx = m_x; nsp = m_sp; npc = m_pc;
        if (use_en_i) begin
            if (use_ptr_i) nx = post_mod(m_x, use_mode_i);
            else           nb = post_mod(m_b, use_mode_i);
        end
        if (push_i)      nsp = m_sp - 8'd1;
        else if (pop_i)  nsp = m_sp + 8'd1;
        if (pc_load_i)                          npc = pc_load_val_i;
        else if (wr_en_i && wr_sel_i == 3'd4)   npc = {m_pc[14:8], wr_data_i};
        else if (wr_en_i && wr_sel_i == 3'd5)   npc = {wr_data_i[6:0], m_pc[7:0]};
        else if (pc_inc_i)                      npc = m_pc + 15'd1;
        if (wr_en_i) begin
            case (wr_sel_i)
                3'd0: na = wr_data_i;
                3'd1: nb = wr_data_i;
                3'd2: nx = wr_data_i;
                3'd3: nsp = wr_data_i;
                default: ;
            endcase
        end
        @(posedge clk);
        m_a = na; m_b = nb; m_x = nx; m_sp = nsp; m_pc = npc;
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en_i = 0; use_en_i = 0; pc_load_i = 0; pc_inc_i = 0;
        push_i = 0; pop_i = 0; use_mode_i = 0;
    endtask

    task automatic wr(logic [2:0] s, logic [7:0] d);
        idle();
        wr_en_i = 1; wr_sel_i = s; wr_data_i = d;
        cycle();
        idle();
    endtask

    // Read every select code with no other activity.
    task automatic readback();
        idle();
        for (int s = 0; s < 8; s++) begin
            rd_sel_i = 3'(s);
            cycle();
        end
    endtask

    initial begin
        #(64'd20 * 64'd200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pc in reset", pc_o, 15'd0);
        rst_n = 1'b1;
        m_a = 0; m_b = 0; m_x = 0; m_pc = 0; m_sp = 8'(RAM_BYTES - 17);
        tag = "R1";
        readback();
        chk("R1 stack init", 15'(m_sp), 15'h2F);

        // R2: every register written and read; codes 6 and 7 have no effect
        tag = "R2";
        wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'hC3); wr(3'd3, 8'h40);
        wr(3'd4, 8'h12); wr(3'd5, 8'h34);
        wr(3'd6, 8'hFF); wr(3'd7, 8'hEE);
        readback();

        // R3: bit 7 of the high-byte write is dropped
        tag = "R3";
        wr(3'd5, 8'hFF);
        rd_sel_i = 3'd5; cycle();
        chk("R3 high byte", 15'(rd_data_o), 15'h7F);

        // R4: carry into the high part and wrap at the top
        tag = "R4";
        idle(); pc_load_i = 1; pc_load_val_i = 15'h00FF; cycle();
        idle(); pc_inc_i = 1; cycle(); idle();
        chk("R4 carry", pc_o, 15'h0100);
        pc_load_i = 1; pc_load_val_i = 15'h7FFF; cycle();
        idle(); pc_inc_i = 1; cycle(); idle();
        chk("R4 wrap", pc_o, 15'h0000);

        // R5: load beats byte write, byte write beats increment
        tag = "R5";
        idle(); pc_load_i = 1; pc_load_val_i = 15'h2345; wr_en_i = 1; wr_sel_i = 3'd4;
        wr_data_i = 8'h99; pc_inc_i = 1; cycle(); idle();
        chk("R5 load wins", pc_o, 15'h2345);
        wr_en_i = 1; wr_sel_i = 3'd4; wr_data_i = 8'h10; pc_inc_i = 1; cycle(); idle();
        chk("R5 write wins", pc_o, 15'h2310);

        // R6: pointer wrap both ways, reserved mode holds
        tag = "R6";
        wr(3'd1, 8'hFF);
        use_en_i = 1; use_ptr_i = 0; use_mode_i = 2'b01; cycle(); idle();
        wr(3'd2, 8'h00);
        use_en_i = 1; use_ptr_i = 1; use_mode_i = 2'b10; cycle(); idle();
        use_en_i = 1; use_ptr_i = 1; use_mode_i = 2'b11; cycle(); idle();
        readback();
        chk("R6 P0 wrapped", 15'(m_b), 15'h00);

        // R7: write in the use cycle wins
        tag = "R7";
        use_en_i = 1; use_ptr_i = 1; use_mode_i = 2'b01;
        wr_en_i = 1; wr_sel_i = 3'd2; wr_data_i = 8'h55; cycle(); idle();
        rd_sel_i = 3'd2; cycle();
        chk("R7 written value", 15'(rd_data_o), 15'h55);

        // R8 and R9: push at 0x00 wraps down, pop at 0xFF wraps up
        tag = "R9";
        wr(3'd3, 8'h00);
        push_i = 1; cycle(); idle();
        rd_sel_i = 3'd3; cycle();
        chk("R9 push wrap", 15'(rd_data_o), 15'hFF);
        pop_i = 1; cycle(); idle();
        tag = "R8";
        push_i = 1; pop_i = 1; use_en_i = 1; cycle(); idle();
        wr_en_i = 1; wr_sel_i = 3'd3; wr_data_i = 8'h77; push_i = 1; cycle(); idle();
        readback();

        // Random mix over all strobes
        tag = "R2 R5 R6 R8 random";
        for (int i = 0; i < 3000; i++) begin
            wr_en_i       = ($urandom % 4) == 0;
            wr_sel_i      = 3'($urandom);
            wr_data_i     = 8'($urandom);
            rd_sel_i      = 3'($urandom);
            use_en_i      = ($urandom % 2) == 0;
            use_ptr_i     = 1'($urandom);
            use_mode_i    = 2'($urandom);
            pc_load_i     = ($urandom % 16) == 0;
            pc_load_val_i = 15'($urandom);
            pc_inc_i      = ($urandom % 2) == 0;
            push_i        = ($urandom % 8) == 0;
            pop_i         = ($urandom % 8) == 0;
            cycle();
        end
        readback();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule